// File: doc/BRIEF.md
# Burst Composition Enumerator

This block lists every way to split a total length `l` into `m` ordered, strictly positive parts. For a burst-error guessing decoder these are the run-length patterns of `m` bursts holding `l` bits in total. A single instance serves both the runs of ones and the runs of zeros. There are C(l-1, m-1) such tuples. The block produces each of them exactly once, one per accepted handshake, and then raises `done`.

Enumeration grows a tree from a single root tuple. A tuple whose first part is at least 2 and that ends in one or more parts equal to 1 is called a parent tuple. Expanding a parent moves an amount `c` (from 1 up to first part minus 1) out of the first part into one of its trailing unit parts. Every tuple produced is emitted. A produced tuple that is itself a parent is pushed onto an on-chip stack and expanded later. The stack depth needed has a closed-form bound, (l-m-1)(m-2), so storage is sized from the parameters and no overflow handling is required.

Top module: `comp_enum`

## Requirements
- R1: After a start with legal `m` and `l`, the first tuple presented is (l-m+1, 1, ..., 1).
- R2: Every presented tuple has exactly `m` parts, each at least 1, that sum to `l`. Part k (k = 0 is the first part) sits in `out_tuple[k*W +: W]`, and the fields for k >= m read 0.
- R3: One run presents C(l-1, m-1) tuples with no repeats, and `out_last` is high on the final one only.
- R4: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_tuple` hold their values.
- R5: With m = 1, or with l = m, exactly one tuple is presented: (l) or (1, ..., 1) respectively. It carries `out_last`.
- R6: A start with m = 0, m > MAX_M, l < m or l > MAX_L presents no tuple and leads straight to `done`.
- R7: `done` is low after reset and while tuples are still flowing. It rises no later than 2 cycles after the final handshake and stays high until the next start.
- R8: A start pulse while a run is in progress is ignored; the run completes with its original `m` and `l`.
- R9: The parent stack never holds more than max over m of (MAX_L-m-1)(m-2) entries (at least 1). It never pops when empty and holds only parent tuples.
- R10: For m >= 2 with more than one tuple, the second tuple presented is (l-m, 2, 1, ..., 1): the root's first child uses c = 1 on the leftmost trailing unit part.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run with `m_i`, `l_i` (taken when idle or done) |
| m_i | input | $clog2(MAX_M+1) | Number of parts |
| l_i | input | $clog2(MAX_L+1) | Total of all parts |
| out_ready | input | 1 | Consumer accepts the presented tuple |
| out_valid | output | 1 | A tuple is presented |
| out_tuple | output | MAX_M*W | Parts, part k at bits [k*W +: W] |
| out_last | output | 1 | Presented tuple is the final one of the run |
| done | output | 1 | Run finished |

## Verification
A corrupted stack entry or a wrong expansion counter shows at the ports within one handshake. It appears as a tuple whose parts no longer sum to `l`, as a repeat of a tuple already seen, or as a tuple missing when `done` rises. Each accepted tuple is therefore checked against an independently enumerated set, and the count and `out_last` are checked at the end of the run. Random backpressure exercises the stall path. The assertions watch stack depth and the sum on every presented cycle, so a bad internal state is flagged on the cycle it first becomes visible.

// File: rtl/comp_pkg.sv
package comp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROOT,
    ST_POP,
    ST_EXPAND,
    ST_DONE
  } comp_state_e;

  // Largest stack occupancy over every legal part count up to max_m.
  function automatic int stack_bound(input int max_m, input int max_l);
    int best;
    best = 1;
    for (int k = 3; k <= max_m; k++) begin
      if ((max_l - k - 1) * (k - 2) > best) best = (max_l - k - 1) * (k - 2);
    end
    return best;
  endfunction

endpackage

// File: rtl/comp_shape.sv
module comp_shape #(
  parameter int MAX_M = 6,
  parameter int W     = 5,
  localparam int MW   = $clog2(MAX_M + 1),
  localparam int TW   = MAX_M * W
) (
  input  logic [TW-1:0] tup,
  input  logic [MW-1:0] m,
  output logic [W-1:0]  head,
  output logic [MW-1:0] tail,
  output logic          mother
);

  logic run;

  always_comb begin
    tail = '0;
    run  = 1'b1;
    for (int k = MAX_M - 1; k >= 1; k--) begin
      if (MW'(k) < m) begin
        if (run && tup[k*W +: W] == W'(1)) tail = tail + MW'(1);
        else run = 1'b0;
      end
    end
    head   = tup[W-1:0];
    mother = (head >= W'(2)) && (tail != '0);
  end

endmodule

// File: rtl/comp_step.sv
module comp_step #(
  parameter int MAX_M = 6,
  parameter int W     = 5,
  localparam int MW   = $clog2(MAX_M + 1),
  localparam int TW   = MAX_M * W
) (
  input  logic [TW-1:0] parent,
  input  logic [W-1:0]  amount,
  input  logic [MW-1:0] pos,
  output logic [TW-1:0] child
);

  always_comb begin
    child         = parent;
    child[W-1:0]  = parent[W-1:0] - amount;
    for (int k = 1; k < MAX_M; k++) begin
      if (MW'(k) == pos) child[k*W +: W] = parent[k*W +: W] + amount;
    end
  end

endmodule

// File: rtl/comp_lifo.sv
module comp_lifo #(
  parameter int DEPTH = 4,
  parameter int DW    = 8,
  localparam int SPW  = $clog2(DEPTH + 1),
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push,
  input  logic           pop,
  input  logic [DW-1:0]  din,
  output logic [DW-1:0]  top,
  output logic [SPW-1:0] count
);

  logic [DW-1:0] mem [DEPTH];

  assign top = (count != '0) ? mem[AW'(count - SPW'(1))] : '0;

  always_ff @(posedge clk) begin
    if (push) mem[AW'(count)] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (push) count <= count + SPW'(1);
    else if (pop)  count <= count - SPW'(1);
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count < SPW'(DEPTH)));

  // R9
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0));

  // R9
  no_push_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop));

endmodule

// File: rtl/comp_enum.sv
module comp_enum #(
  parameter int MAX_M  = 6,
  parameter int MAX_L  = 16,
  localparam int W     = $clog2(MAX_L + 1),
  localparam int MW    = $clog2(MAX_M + 1),
  localparam int TW    = MAX_M * W,
  localparam int DEPTH = comp_pkg::stack_bound(MAX_M, MAX_L)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [MW-1:0] m_i,
  input  logic [W-1:0]  l_i,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [TW-1:0] out_tuple,
  output logic          out_last,
  output logic          done
);
  import comp_pkg::*;

  localparam int SPW = $clog2(DEPTH + 1);

  function automatic logic [TW-1:0] mk_root(input logic [MW-1:0] mm, input logic [W-1:0] ll);
    logic [TW-1:0] r;
    r = '0;
    r[W-1:0] = ll - W'(mm) + W'(1);
    for (int k = 1; k < MAX_M; k++) begin
      if (MW'(k) < mm) r[k*W +: W] = W'(1);
    end
    return r;
  endfunction

  function automatic logic [W+3:0] tuple_sum(input logic [TW-1:0] t);
    logic [W+3:0] s;
    s = '0;
    for (int k = 0; k < MAX_M; k++) s = s + (W+4)'(t[k*W +: W]);
    return s;
  endfunction

  comp_state_e   state;
  logic [MW-1:0] m_q;
  logic [W-1:0]  l_q;
  logic [TW-1:0] par_q;
  logic [W-1:0]  a1_q;
  logic [MW-1:0] f_q;
  logic [W-1:0]  c1_q;
  logic [MW-1:0] p_q;

  logic [TW-1:0] child;
  logic [TW-1:0] top_tuple;
  logic [SPW-1:0] sp;
  logic [W-1:0]  out_head, top_head;
  logic [MW-1:0] out_tail, top_tail;
  logic          out_mother, top_mother;

  logic params_ok, can_start, fire, push, pop, step_end, sp_empty;

  assign params_ok = (m_i != '0) && (m_i <= MW'(MAX_M)) && (l_i >= W'(m_i)) && (l_i <= W'(MAX_L));
  assign can_start = (state == ST_IDLE) || (state == ST_DONE);

  comp_step #(.MAX_M(MAX_M), .W(W)) u_step (
    .parent(par_q), .amount(c1_q), .pos(p_q), .child(child)
  );

  assign out_valid = (state == ST_ROOT) || (state == ST_EXPAND);
  assign out_tuple = (state == ST_ROOT) ? par_q : child;
  assign fire      = out_valid && out_ready;

  comp_shape #(.MAX_M(MAX_M), .W(W)) u_out_shape (
    .tup(out_tuple), .m(m_q), .head(out_head), .tail(out_tail), .mother(out_mother)
  );

  assign push     = fire && out_mother;
  assign pop      = (state == ST_POP) && (sp != '0);
  assign sp_empty = (sp == '0);
  assign step_end = (p_q == m_q - MW'(1)) && (c1_q == a1_q - W'(1));

  comp_lifo #(.DEPTH(DEPTH), .DW(TW)) u_lifo (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .din(out_tuple), .top(top_tuple), .count(sp)
  );

  comp_shape #(.MAX_M(MAX_M), .W(W)) u_top_shape (
    .tup(top_tuple), .m(m_q), .head(top_head), .tail(top_tail), .mother(top_mother)
  );

  assign out_last = out_valid && sp_empty &&
                    ((state == ST_ROOT) ? !out_mother
                                        : (out_head == W'(1) && out_tail == '0));
  assign done = (state == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      m_q   <= '0;
      l_q   <= '0;
      par_q <= '0;
      a1_q  <= '0;
      f_q   <= '0;
      c1_q  <= '0;
      p_q   <= '0;
    end else begin
      unique case (state)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            m_q <= m_i;
            l_q <= l_i;
            if (params_ok) begin
              par_q <= mk_root(m_i, l_i);
              state <= ST_ROOT;
            end else begin
              state <= ST_DONE;
            end
          end
        end
        ST_ROOT: begin
          if (fire) state <= out_mother ? ST_POP : ST_DONE;
        end
        ST_POP: begin
          if (sp_empty) begin
            state <= ST_DONE;
          end else begin
            par_q <= top_tuple;
            a1_q  <= top_head;
            f_q   <= top_tail;
            c1_q  <= W'(1);
            p_q   <= m_q - top_tail;
            state <= ST_EXPAND;
          end
        end
        ST_EXPAND: begin
          if (fire) begin
            if (p_q == m_q - MW'(1)) begin
              p_q <= m_q - f_q;
              if (step_end) state <= ST_POP;
              else c1_q <= c1_q + W'(1);
            end else begin
              p_q <= p_q + MW'(1);
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  sum_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (tuple_sum(out_tuple) == (W+4)'(l_q)));

  // R4
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_tuple)));

  // R3
  last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && out_last) |=> !out_valid);

  // R6
  bad_params_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (can_start && start && !params_ok) |=> (done && !out_valid));

  // R9
  stack_mother_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> top_mother);

  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!can_start && start) |=> ($stable(m_q) && $stable(l_q)));

endmodule

// File: tb/sim_comp_enum.sv
module sim_comp_enum;
  localparam int MAX_M = 6;
  localparam int MAX_L = 16;
  localparam int W     = $clog2(MAX_L + 1);
  localparam int MW    = $clog2(MAX_M + 1);
  localparam int TW    = MAX_M * W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [MW-1:0] m_i = '0;
  logic [W-1:0]  l_i = '0;
  logic          out_ready = 1'b0;
  logic          out_valid;
  logic [TW-1:0] out_tuple;
  logic          out_last;
  logic          done;

  always #4 clk = ~clk;

  comp_enum #(.MAX_M(MAX_M), .MAX_L(MAX_L)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .m_i(m_i), .l_i(l_i),
    .out_ready(out_ready), .out_valid(out_valid), .out_tuple(out_tuple),
    .out_last(out_last), .done(done)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  logic [TW-1:0] exp_q[$];
  bit            exp_set[logic [TW-1:0]];
  bit            seen[logic [TW-1:0]];
  int            got;
  int            last_fire_cyc;
  bit            active = 1'b0;
  int            cur_m, cur_l;
  logic [TW-1:0] root_t, second_t;
  int            ready_mode = 0;
  bit            hold = 1'b0;
  logic [TW-1:0] held_t;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic build_expected(input int m, input int l);
    exp_q.delete();
    exp_set.delete();
    seen.delete();
    root_t   = '0;
    second_t = '0;
    if (m < 1 || m > MAX_M || l < m || l > MAX_L) return;
    for (int mask = 0; mask < (1 << (l - 1)); mask++) begin
      if ($countones(mask) == m - 1) begin
        logic [TW-1:0] t;
        int idx, run_len;
        t = '0; idx = 0; run_len = 1;
        for (int b = 0; b < l - 1; b++) begin
          if (mask[b]) begin
            t[idx*W +: W] = W'(run_len);
            idx++;
            run_len = 1;
          end else run_len++;
        end
        t[idx*W +: W] = W'(run_len);
        exp_q.push_back(t);
        exp_set[t] = 1'b1;
      end
    end
    root_t[W-1:0] = W'(l - m + 1);
    for (int k = 1; k < m; k++) root_t[k*W +: W] = W'(1);
    if (m >= 2) begin
      second_t = root_t;
      second_t[W-1:0]    = W'(l - m);
      second_t[1*W +: W] = W'(2);
    end
  endtask

  // ready driver
  initial begin
    forever begin
      @(posedge clk);
      #1;
      out_ready = (ready_mode == 0) ? 1'b1 : 1'($urandom_range(0, 1));
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && active) begin
      if (hold) begin
        check(out_valid == 1'b1, "R4", "valid held under stall", out_valid, 1);
        check(out_tuple == held_t, "R4", "tuple held under stall", out_tuple, held_t);
        hold = 1'b0;
      end
      if (out_valid && out_ready) begin
        int s;
        bit shape_ok;
        got++;
        last_fire_cyc = cyc;
        s = 0; shape_ok = 1'b1;
        for (int k = 0; k < MAX_M; k++) begin
          int e;
          e = int'(out_tuple[k*W +: W]);
          s += e;
          if (k < cur_m && e < 1) shape_ok = 1'b0;
          if (k >= cur_m && e != 0) shape_ok = 1'b0;
        end
        check(shape_ok, "R2", "part shape", out_tuple, 0);
        check(s == cur_l, "R2", "part sum", s, cur_l);
        check(exp_set.exists(out_tuple), "R3", "tuple in expected set", out_tuple, 1);
        check(!seen.exists(out_tuple), "R3", "no repeat", got, 0);
        seen[out_tuple] = 1'b1;
        check(out_last == (got == exp_q.size()), "R3", "last flag", out_last, got == exp_q.size());
        check(done == 1'b0, "R7", "done low while flowing", done, 0);
        if (got == 1)
          check(out_tuple == root_t, "R1", "first tuple", out_tuple, root_t);
        if (got == 2 && cur_m >= 2)
          check(out_tuple == second_t, "R10", "second tuple", out_tuple, second_t);
      end else if (out_valid && !out_ready) begin
        hold   = 1'b1;
        held_t = out_tuple;
      end
    end
  end

  task automatic run(input int m, input int l, input int mode, input bit poke, input string req);
    int waited;
    build_expected(m, l);
    ready_mode = mode;
    cur_m = m; cur_l = l;
    got = 0; last_fire_cyc = -1; hold = 1'b0;
    active = 1'b1;
    @(posedge clk); #1;
    m_i = MW'(m); l_i = W'(l); start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    if (poke) begin
      repeat (10) @(posedge clk);
      #1;
      m_i = MW'(2); l_i = W'(5); start = 1'b1; // R8: must be ignored
      @(posedge clk); #1;
      start = 1'b0;
    end
    waited = 0;
    @(negedge clk);
    while (!done && waited < 40000) begin
      @(negedge clk);
      waited++;
    end
    check(done == 1'b1, req, "run reached done", done, 1);
    check(got == exp_q.size(), req, "tuple count", got, exp_q.size());
    if (got > 0)
      check(cyc - last_fire_cyc <= 2, "R7", "done latency", cyc - last_fire_cyc, 2);
    repeat (3) @(negedge clk);
    check(done == 1'b1 && out_valid == 1'b0, "R7", "done held, idle output", done, 1);
    active = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    check(out_valid == 1'b0, "R7", "reset valid", out_valid, 0);
    check(done == 1'b0, "R7", "reset done", done, 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    run(3, 6, 0, 1'b0, "R3");
    run(4, 8, 1, 1'b0, "R4");
    run(1, 5, 0, 1'b0, "R5");
    run(2, 2, 1, 1'b0, "R5");
    run(5, 5, 0, 1'b0, "R5");
    run(2, 9, 1, 1'b0, "R10");
    run(4, 9, 0, 1'b1, "R8");
    run(6, 12, 1, 1'b0, "R3");
    run(6, 16, 1, 1'b0, "R9");
    run(0, 5, 0, 1'b0, "R6");
    run(7, 10, 0, 1'b0, "R6");
    run(4, 3, 0, 1'b0, "R6");
    run(3, 20, 0, 1'b0, "R6");
    run(3, 7, 1, 1'b0, "R1");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL R7 watchdog: cycles %0d expected below %0d", cyc, 190000);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule